// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes the byte stream of a received Ethernet frame and stores it into host-owned buffers described by a ring of eight receive descriptors. Each descriptor names a buffer and carries ownership and status flags. The block fills a buffer and, if the frame is longer, moves to the next descriptor in the ring. When the frame is complete it hands every descriptor the frame used back to the host and can raise an interrupt.

In half-duplex mode, a collision during a frame discards that frame. Nothing it touched in the ring is handed over, and the ring pointer moves back to where the frame began. A late collision is not discarded in this way. That frame is delivered with a flag set, so the host can see the fault on the wire.

The input is a valid/ready byte stream. A beat is taken only in a cycle where `in_valid` and `in_ready` are both high. The source must hold the beat and its flags stable until that happens. `in_ready` goes low for exactly one cycle per descriptor while the block writes descriptors back. It is high at every other time, including while the rest of a dropped frame is being discarded. The host port and the buffer read port are plain, combinational-read ports. The host may write a descriptor only when that descriptor is not in use by a frame.

Top module: `rxbd_mgr`

## Requirements
- R1: A descriptor word is {buf_idx[29:22], len[21:6], ovr[5], late[4], ien[3], last[2], wrap[1], empty[0]}. Byte k of the frame is stored in buffer memory at buf_idx*BUF_SZ + (k mod BUF_SZ), in the buffer of the descriptor holding it.
- R2: On close, every descriptor a frame used has `empty` cleared. The final one carries last=1 and len equal to the stored byte count. Each earlier one carries last=0, late=0, ovr=0 and len=BUF_SZ. The other fields are kept.
- R3: When a buffer is full and another byte arrives, the block moves to the next descriptor if that descriptor has empty=1. The next descriptor is index 0 when the current one has wrap=1, otherwise the following index (index 7 is followed by 0).
- R4: If the next descriptor has empty=0, or is the descriptor where the frame started, the byte is dropped. The current descriptor is closed with ovr=1, and every remaining beat of the frame is discarded.
- R5: With full_duplex=0, `in_coll` on any beat of a frame aborts the frame. No descriptor is changed, and the next frame starts at the descriptor where the aborted frame started.
- R6: With full_duplex=1, `in_coll` has no effect, and the frame is delivered normally.
- R7: `in_late_coll` on any stored beat of a frame delivers the frame normally with late=1 in its final descriptor.
- R8: `irq` pulses high for one cycle after a frame closes, only if the final descriptor has ien=1 and `irq_enable` is high.
- R9: A frame whose first descriptor has empty=0 is dropped completely, and the ring is unchanged.
- R10: `in_ready` is low for exactly one cycle per descriptor handed back, and high otherwise.
- R11: After reset all descriptors read zero, the ring pointer is 0, `irq` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1: collisions ignored; 0: half duplex |
| irq_enable | input | 1 | Global interrupt enable |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| in_coll | input | 1 | Collision seen on this beat |
| in_late_coll | input | 1 | Late collision seen on this beat |
| host_we | input | 1 | Host descriptor write strobe |
| host_addr | input | 3 | Descriptor index for host read/write |
| host_wdata | input | 30 | Descriptor word to write |
| host_rdata | output | 30 | Descriptor word at host_addr |
| buf_raddr | input | 9 | Buffer memory byte address |
| buf_rdata | output | 8 | Buffer memory byte |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The hardest states to reach are the ones where a frame has already spilled into a second descriptor before it is aborted. One is a collision that must roll back across a buffer boundary. The other is an overrun caused by the ring wrapping around onto the frame's own first descriptor. The stimulus reaches both by preloading the ring with a chosen pattern of empty, wrap and interrupt bits. It then sends frames whose lengths and collision positions are set relative to the 64-byte buffer, such as a collision on byte 66 and a 600-byte frame into a fully armed ring. A behavioural ring model predicts the descriptor words, the buffer bytes, the interrupt count and the number of stall cycles.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  typedef struct packed {
    logic [7:0]  buf_idx;
    logic [15:0] len;
    logic        ovr;
    logic        late;
    logic        ien;
    logic        last;
    logic        wrap;
    logic        empty;
  } rxd_t;

  localparam int DESC_W = $bits(rxd_t);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP, S_CLOSE} rx_state_e;

endpackage

// File: rtl/rxbd_ring.sv
module rxbd_ring import rxbd_pkg::*; #(
  parameter int NDESC = 8,
  localparam int PW = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [PW-1:0] host_addr,
  input  rxd_t          host_wdata,
  output rxd_t          host_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_addr,
  input  rxd_t          eng_wdata,
  input  logic [PW-1:0] rd_a_addr,
  output rxd_t          rd_a,
  input  logic [PW-1:0] rd_b_addr,
  output rxd_t          rd_b
);

  rxd_t ent [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[g] <= '0;
      else if (eng_we && eng_addr == PW'(g))
        ent[g] <= eng_wdata;
      else if (host_we && host_addr == PW'(g))
        ent[g] <= host_wdata;
    end
  end

  assign host_rdata = ent[host_addr];
  assign rd_a       = ent[rd_a_addr];
  assign rd_b       = ent[rd_b_addr];

  // R2: every engine write-back hands the descriptor to the host
  a_r2_close_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !eng_wdata.empty);

  // R4: overrun status only ever appears on a frame's final descriptor
  a_r4_overrun_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && eng_wdata.ovr) |-> eng_wdata.last);

endmodule

// File: rtl/rxbd_bufmem.sv
module rxbd_bufmem #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl import rxbd_pkg::*; #(
  parameter int NDESC  = 8,
  parameter int BUF_SZ = 64,
  parameter int NBUF   = 8,
  localparam int PW = $clog2(NDESC),
  localparam int OW = $clog2(BUF_SZ + 1),
  localparam int AW = $clog2(NBUF * BUF_SZ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          irq_enable,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_coll,
  input  logic          in_late_coll,
  output logic [PW-1:0] rd_a_addr,
  input  rxd_t          rd_a,
  output logic [PW-1:0] rd_b_addr,
  input  rxd_t          rd_b,
  output logic          eng_we,
  output logic [PW-1:0] eng_addr,
  output rxd_t          eng_wdata,
  output logic          bw_we,
  output logic [AW-1:0] bw_addr,
  output logic [7:0]    bw_data,
  output logic          irq
);

  rx_state_e     state_q, state_n;
  logic [PW-1:0] cur_q, cur_n, start_q, start_n, walk_q, walk_n, nxt_a;
  logic [OW-1:0] off_q, off_n;
  logic [15:0]   tot_q, tot_n;
  logic          lc_q, lc_n, ov_q, ov_n, drop_q, drop_n, irq_q, irq_n;
  logic          acc, coll_hit;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic wrap);
    if (wrap || p == PW'(NDESC - 1)) return '0;
    return p + PW'(1);
  endfunction

  function automatic logic [AW-1:0] baddr(input logic [7:0] idx, input logic [OW-1:0] off);
    return AW'(int'(idx) * BUF_SZ + int'(off));
  endfunction

  assign in_ready  = (state_q != S_CLOSE);
  assign acc       = in_valid && in_ready;
  assign coll_hit  = in_coll && !full_duplex;
  assign rd_a_addr = (state_q == S_CLOSE) ? walk_q : cur_q;
  assign nxt_a     = step(cur_q, rd_a.wrap);
  assign rd_b_addr = nxt_a;
  assign bw_data   = in_data;
  assign irq       = irq_q;

  always_comb begin
    state_n = state_q; cur_n = cur_q; start_n = start_q; walk_n = walk_q;
    off_n = off_q; tot_n = tot_q; lc_n = lc_q; ov_n = ov_q; drop_n = drop_q;
    irq_n = 1'b0;
    bw_we = 1'b0; bw_addr = '0;
    eng_we = 1'b0; eng_addr = walk_q; eng_wdata = rd_a;
    unique case (state_q)
      S_IDLE: begin
        if (acc && in_sof) begin
          if (!rd_a.empty || coll_hit) begin
            state_n = in_eof ? S_IDLE : S_DROP;
          end else begin
            bw_we   = 1'b1;
            bw_addr = baddr(rd_a.buf_idx, '0);
            start_n = cur_q;
            walk_n  = cur_q;
            off_n   = OW'(1);
            tot_n   = 16'd1;
            lc_n    = in_late_coll;
            ov_n    = 1'b0;
            drop_n  = 1'b0;
            state_n = in_eof ? S_CLOSE : S_RECV;
          end
        end
      end
      S_RECV: begin
        if (acc) begin
          lc_n = lc_q | in_late_coll;
          if (coll_hit) begin
            cur_n   = start_q;
            walk_n  = start_q;
            state_n = in_eof ? S_IDLE : S_DROP;
          end else if (off_q < OW'(BUF_SZ)) begin
            bw_we   = 1'b1;
            bw_addr = baddr(rd_a.buf_idx, off_q);
            off_n   = off_q + OW'(1);
            tot_n   = tot_q + 16'd1;
            if (in_eof) state_n = S_CLOSE;
          end else if (rd_b.empty && nxt_a != start_q) begin
            bw_we   = 1'b1;
            bw_addr = baddr(rd_b.buf_idx, '0);
            cur_n   = nxt_a;
            off_n   = OW'(1);
            tot_n   = tot_q + 16'd1;
            if (in_eof) state_n = S_CLOSE;
          end else begin
            ov_n    = 1'b1;
            drop_n  = !in_eof;
            state_n = S_CLOSE;
          end
        end
      end
      S_CLOSE: begin
        eng_we          = 1'b1;
        eng_wdata.empty = 1'b0;
        if (walk_q == cur_q) begin
          eng_wdata.len  = tot_q;
          eng_wdata.last = 1'b1;
          eng_wdata.late = lc_q;
          eng_wdata.ovr  = ov_q;
          irq_n          = rd_a.ien && irq_enable;
          cur_n          = step(cur_q, rd_a.wrap);
          state_n        = drop_q ? S_DROP : S_IDLE;
        end else begin
          eng_wdata.len  = 16'(BUF_SZ);
          eng_wdata.last = 1'b0;
          eng_wdata.late = 1'b0;
          eng_wdata.ovr  = 1'b0;
          walk_n         = step(walk_q, rd_a.wrap);
        end
      end
      S_DROP: begin
        if (acc && in_eof) state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE; cur_q <= '0; start_q <= '0; walk_q <= '0;
      off_q <= '0; tot_q <= '0; lc_q <= 1'b0; ov_q <= 1'b0; drop_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      state_q <= state_n; cur_q <= cur_n; start_q <= start_n; walk_q <= walk_n;
      off_q <= off_n; tot_q <= tot_n; lc_q <= lc_n; ov_q <= ov_n; drop_q <= drop_n;
      irq_q <= irq_n;
    end
  end

  // R3: fill level of the current buffer never passes its size
  a_r3_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OW'(BUF_SZ));

  // R5: a half-duplex collision mid-frame returns the pointer to the frame start
  a_r5_rollback_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECV && acc && coll_hit) |=> (cur_q == $past(start_q)));

  // R8: interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8: interrupt only when globally enabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(irq_enable));

endmodule

// File: rtl/rxbd_mgr.sv
module rxbd_mgr import rxbd_pkg::*; #(
  parameter int NDESC  = 8,
  parameter int BUF_SZ = 64,
  parameter int NBUF   = 8,
  localparam int PW = $clog2(NDESC),
  localparam int AW = $clog2(NBUF * BUF_SZ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              irq_enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_coll,
  input  logic              in_late_coll,
  input  logic              host_we,
  input  logic [PW-1:0]     host_addr,
  input  logic [DESC_W-1:0] host_wdata,
  output logic [DESC_W-1:0] host_rdata,
  input  logic [AW-1:0]     buf_raddr,
  output logic [7:0]        buf_rdata,
  output logic              irq
);

  rxd_t          rd_a, rd_b, eng_wdata, h_rd;
  logic [PW-1:0] rd_a_addr, rd_b_addr, eng_addr;
  logic          eng_we, bw_we;
  logic [AW-1:0] bw_addr;
  logic [7:0]    bw_data;

  rxbd_ctrl #(.NDESC(NDESC), .BUF_SZ(BUF_SZ), .NBUF(NBUF)) u_ctrl (
    .clk, .rst_n, .full_duplex, .irq_enable, .in_valid, .in_ready, .in_data,
    .in_sof, .in_eof, .in_coll, .in_late_coll,
    .rd_a_addr, .rd_a, .rd_b_addr, .rd_b,
    .eng_we, .eng_addr, .eng_wdata, .bw_we, .bw_addr, .bw_data, .irq
  );

  rxbd_ring #(.NDESC(NDESC)) u_ring (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata(rxd_t'(host_wdata)),
    .host_rdata(h_rd), .eng_we, .eng_addr, .eng_wdata,
    .rd_a_addr, .rd_a, .rd_b_addr, .rd_b
  );

  rxbd_bufmem #(.DEPTH(NBUF * BUF_SZ)) u_buf (
    .clk, .rst_n, .we(bw_we), .waddr(bw_addr), .wdata(bw_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  assign host_rdata = h_rd;

endmodule

// File: tb/sim_rxbd_mgr.sv
module sim_rxbd_mgr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic full_duplex = 1'b0, irq_enable = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_coll = 1'b0, in_late_coll = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, irq;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [29:0] host_wdata = '0, host_rdata;
  logic [8:0] buf_raddr = '0;
  logic [7:0] buf_rdata;

  always #5 clk = ~clk;

  rxbd_mgr u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [29:0] md [8];
  logic [7:0]  mb [512];
  int mcur = 0, exp_irq = 0, exp_low = 0, irq_seen = 0, ready_low = 0;
  logic irq_prev = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_ready) ready_low++;
      if (irq) begin
        irq_seen++;
        check(!irq_prev, "R8 irq single pulse", 1, 0);
      end
      irq_prev = irq;
    end
  end

  function automatic logic [29:0] mk(input int idx, input bit wrap, input bit ien);
    return {8'(idx), 16'd0, 1'b0, 1'b0, ien, 1'b0, wrap, 1'b1};
  endfunction

  function automatic int nxt(input int p);
    return md[p][1] ? 0 : (p + 1) % 8;
  endfunction

  task automatic host_wr(input int a, input logic [29:0] v);
    host_we = 1'b1; host_addr = 3'(a); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    md[a] = v;
  endtask

  task automatic compare_all(input string req);
    bit ok = 1'b1;
    int bad = -1;
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a); #1;
      check(host_rdata === md[a], req, host_rdata, md[a]);
    end
    for (int k = 0; k < 512; k++) begin
      buf_raddr = 9'(k); #1;
      if (ok && buf_rdata !== mb[k]) begin ok = 1'b0; bad = k; end
    end
    check(ok, {req, " R1 buffer bytes"}, bad, -1);
  endtask

  // model: collision beats at coll_at, late collision at late_at (-1 = none)
  task automatic send(input int n, input int coll_at, input int late_at, input int seed, input string req);
    logic [7:0] b;
    int start, cur, off, tot, used[$];
    bit ov = 0, lc = 0, rolled = 0, dropped = 0;
    logic [29:0] d;
    exp_irq = 0; exp_low = 0;
    if (md[mcur][0] == 1'b0 || (!full_duplex && coll_at == 0)) dropped = 1;
    else begin
      start = mcur; cur = mcur; off = 0; tot = 0; used.push_back(cur);
      for (int i = 0; i < n; i++) begin
        b = 8'(seed + i * 7);
        if (!full_duplex && coll_at == i) begin rolled = 1; break; end
        if (late_at == i) lc = 1;
        if (off == 64) begin
          if (md[nxt(cur)][0] && nxt(cur) != start) begin
            cur = nxt(cur); off = 0; used.push_back(cur);
          end else begin ov = 1; break; end
        end
        mb[int'(md[cur][29:22]) * 64 + off] = b;
        off++; tot++;
      end
      if (!rolled) begin
        foreach (used[k]) begin
          d = md[used[k]];
          d[0] = 1'b0;
          if (k == used.size() - 1) begin
            d[21:6] = 16'(tot); d[2] = 1'b1; d[4] = lc; d[5] = ov;
          end else begin
            d[21:6] = 16'd64; d[2] = 1'b0; d[4] = 1'b0; d[5] = 1'b0;
          end
          md[used[k]] = d;
        end
        exp_low = used.size();
        exp_irq = (md[cur][3] && irq_enable) ? 1 : 0;
        mcur = nxt(cur);
      end
    end
    ready_low = 0; irq_seen = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = 8'(seed + i * 7);
      in_sof = (i == 0); in_eof = (i == n - 1);
      in_coll = (i == coll_at); in_late_coll = (i == late_at);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 0; in_eof = 0; in_coll = 0; in_late_coll = 0;
    repeat (20) @(negedge clk);
    check(irq_seen == exp_irq, {req, " R8 irq count"}, irq_seen, exp_irq);
    check(ready_low == exp_low, {req, " R10 stall cycles"}, ready_low, exp_low);
    compare_all(req);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 8; a++) md[a] = '0;
    for (int k = 0; k < 512; k++) mb[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(in_ready === 1'b1, "R11 in_ready after reset", in_ready, 1);
    check(irq === 1'b0, "R11 irq after reset", irq, 0);
    compare_all("R11 reset ring");
    for (int a = 0; a < 8; a++) host_wr(a, mk(a, a == 7, a != 7));
    send(10, -1, -1, 3, "R1 R2 short frame");
    send(150, -1, -1, 40, "R2 R3 spill frame");
    send(40, 20, -1, 90, "R5 collision");
    send(70, 66, -1, 11, "R5 collision after spill");
    full_duplex = 1'b1;
    send(30, 5, -1, 17, "R6 full duplex collision");
    full_duplex = 1'b0;
    send(20, -1, 9, 55, "R7 late collision");
    irq_enable = 1'b0;
    send(5, -1, -1, 77, "R8 irq disabled");
    irq_enable = 1'b1;
    send(64, -1, -1, 101, "R8 R3 exact buffer ien off wrap");
    host_wr(0, mk(0, 0, 1));
    host_wr(1, mk(1, 0, 1));
    send(200, -1, -1, 5, "R4 overrun not empty");
    send(30, -1, -1, 9, "R9 no descriptor");
    for (int a = 0; a < 8; a++) host_wr(a, mk(a, a == 7, 1));
    send(600, -1, -1, 13, "R4 R3 overrun on own start");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule